// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous burst SRAM whose inputs and outputs are all registered. A new read or write may be issued on every enabled clock, in any order, and the shared data bus carries one word per clock with no idle cycle when the direction changes. Write data is deliberately delayed so that it occupies the bus in the same relative cycle that read data would. Turning the bus around from read to write therefore costs nothing.

Each operation either loads a new address or advances a 2-bit burst counter on the low address bits, stepping through the word group in linear or interleaved order. Writes are masked per byte lane. A clock-enable input freezes the whole pipeline. A sleep input stops new operations from being accepted. The output driver enable is derived inside the block from the pipeline state, so no external output-enable timing is needed. A read that follows a still-pending write to the same word returns the new bytes merged over the old ones.

Top module: `nowait_sram`

## Requirements
- R1: After synchronous reset, `dout_oe` is 0 and no operation is in flight. The first two enabled edges after reset produce no read data.
- R2: A read accepted at enabled edge k drives its word on `dout` with `dout_oe`=1 after enabled edge k+2. Every enabled edge delivers the result of the next operation.
- R3: For a write accepted at enabled edge k, the write data is driven on `din` during the cycle that follows enabled edge k+2, and is sampled at enabled edge k+3. `dout_oe` is 0 in that cycle.
- R4: Reads and writes run back to back in any mix with no wait state. A read returns the most recent data written to its word, even when that write was accepted one or two operations earlier.
- R5: `byte_we[i]` (active high) guards `din[8i+7:8i]`. Only enabled lanes of the target word change. A read that closely follows partial writes returns the merged word.
- R6: With `clk_en`=0, a clock edge has no effect: `dout`, `dout_oe` and all pipeline state hold. Latencies count only enabled edges.
- R7: With `sleep`=1 at an enabled edge, no operation is accepted, including an advance, and the burst counter does not step. Operations already in flight complete.
- R8: `adv`=0 loads `addr` and takes the operation type from `we` (1 = write). `adv`=1 moves to the next burst address, keeps the operation type of the last load, and ignores `we` and `addr`. `byte_we` is always taken from the current cycle.
- R9: Linear order (`burst_il`=0 at load): the n-th advance after a load with low address bits s uses low bits (s+n) mod 4. Upper address bits stay fixed.
- R10: Interleaved order (`burst_il`=1 at load): the n-th advance uses low bits s XOR n. The order is fixed by `burst_il` at the load.
- R11: `dout_oe` is 1 exactly in cycles that carry read data, and 0 in write-data and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; 0 freezes the pipeline |
| sleep | input | 1 | 1 blocks acceptance of new operations |
| addr | input | ADDR_W | Word address for a load |
| we | input | 1 | Operation on load: 1 write, 0 read |
| adv | input | 1 | 1 continue burst, 0 load new address |
| burst_il | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| byte_we | input | LANES | Per-lane write enables |
| din | input | LANES*LANE_W | Write data (bus input side) |
| dout | output | LANES*LANE_W | Read data (bus output side) |
| dout_oe | output | 1 | Bus drive enable, high in read-data cycles |

## Verification
Most internal faults reach the ports as a wrong word or a misplaced `dout_oe`, exactly two enabled edges after the affected command. A stale forwarding path shows up only when a read follows a write to the same word at distance one or two, so the stimulus places reads at both distances, with full and partial byte masks. A burst counter that steps wrongly, or that moves during sleep, corrupts the address of every later advance. This is seen on the next read in that burst. A clock-enable leak changes `dout` on a frozen edge.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;

    localparam int unsigned BURST_W = 2;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } sram_op_e;

    // Low address bits for burst step n from start offset s.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] s,
        input logic [BURST_W-1:0] n,
        input logic               il
    );
        return il ? (s ^ n) : (s + n);
    endfunction

endpackage

// File: rtl/nw_cmd_reg.sv
module nw_cmd_reg
    import nwsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              adv,
    input  logic              burst_il,
    input  logic [LANES-1:0]  byte_we,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_addr,
    output sram_op_e          q_op,
    output logic              q_adv,
    output logic              q_il,
    output logic [LANES-1:0]  q_be
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_addr  <= '0;
            q_op    <= OP_READ;
            q_adv   <= 1'b0;
            q_il    <= 1'b0;
            q_be    <= '0;
        end else if (clk_en) begin
            q_valid <= !sleep;
            q_addr  <= addr;
            q_op    <= we ? OP_WRITE : OP_READ;
            q_adv   <= adv;
            q_il    <= burst_il;
            q_be    <= byte_we;
        end
    end

endmodule

// File: rtl/nw_burst.sv
module nw_burst
    import nwsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clk_en,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  sram_op_e           in_op,
    input  logic               in_adv,
    input  logic               in_il,
    input  logic [LANES-1:0]   in_be,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output sram_op_e           out_op,
    output logic [LANES-1:0]   out_be,
    output logic [BURST_W-1:0] cnt
);

    logic [ADDR_W-1:0]  base;
    logic               base_il;
    sram_op_e           base_op;
    logic [BURST_W-1:0] cnt_next;
    logic [ADDR_W-1:0]  eff_addr;
    sram_op_e           eff_op;

    always_comb begin
        cnt_next = cnt + BURST_W'(1);
        if (in_adv) begin
            eff_addr = {base[ADDR_W-1:BURST_W],
                        burst_low(base[BURST_W-1:0], cnt_next, base_il)};
            eff_op   = base_op;
        end else begin
            eff_addr = in_addr;
            eff_op   = in_op;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_op    <= OP_READ;
            out_be    <= '0;
            base      <= '0;
            base_il   <= 1'b0;
            base_op   <= OP_READ;
            cnt       <= '0;
        end else if (clk_en) begin
            out_valid <= in_valid;
            out_addr  <= eff_addr;
            out_op    <= eff_op;
            out_be    <= in_be;
            if (in_valid) begin
                if (in_adv) begin
                    cnt <= cnt_next;
                end else begin
                    base    <= in_addr;
                    base_il <= in_il;
                    base_op <= in_op;
                    cnt     <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/nw_store.sv
module nw_store #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = LANES * LANE_W,
    localparam int unsigned DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write buffer: data captured from the bus, committed one edge later.
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [LANES-1:0]  wb_be;
    logic [DATA_W-1:0] wb_data;

    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] rd_word;
    logic              wb_hit;
    logic              bus_hit;

    assign arr_word = mem[rd_addr];
    assign wb_hit   = wb_valid && (wb_addr == rd_addr);
    assign bus_hit  = bus_wr && (bus_addr == rd_addr);

    // Per-lane merge: bus data is newer than buffered data, which is newer than the array.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_word[g*LANE_W +: LANE_W] =
            (bus_hit && bus_be[g]) ? din[g*LANE_W +: LANE_W] :
            (wb_hit  && wb_be[g])  ? wb_data[g*LANE_W +: LANE_W] :
                                     arr_word[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (clk_en && wb_valid) begin
            for (int i = 0; i < LANES; i++) begin
                if (wb_be[i]) begin
                    mem[wb_addr][i*LANE_W +: LANE_W] <= wb_data[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_be    <= '0;
            wb_data  <= '0;
            dout     <= '0;
            dout_oe  <= 1'b0;
        end else if (clk_en) begin
            wb_valid <= bus_wr;
            wb_addr  <= bus_addr;
            wb_be    <= bus_be;
            wb_data  <= din;
            dout_oe  <= rd_valid;
            if (rd_valid) begin
                dout <= rd_word;
            end
        end
    end

endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
    import nwsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              adv,
    input  logic              burst_il,
    input  logic [LANES-1:0]  byte_we,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    // Stage 1: registered command
    logic               s1_valid;
    logic [ADDR_W-1:0]  s1_addr;
    sram_op_e           s1_op;
    logic               s1_adv;
    logic               s1_il;
    logic [LANES-1:0]   s1_be;

    // Stage 2: resolved address
    logic               s2_valid;
    logic [ADDR_W-1:0]  s2_addr;
    sram_op_e           s2_op;
    logic [LANES-1:0]   s2_be;
    logic [BURST_W-1:0] burst_cnt;

    // Stage 3: bus cycle (read data out or write data in)
    logic               s3_valid;
    logic [ADDR_W-1:0]  s3_addr;
    sram_op_e           s3_op;
    logic [LANES-1:0]   s3_be;

    logic s2_rd;
    logic s3_wr;

    nw_cmd_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .sleep    (sleep),
        .addr     (addr),
        .we       (we),
        .adv      (adv),
        .burst_il (burst_il),
        .byte_we  (byte_we),
        .q_valid  (s1_valid),
        .q_addr   (s1_addr),
        .q_op     (s1_op),
        .q_adv    (s1_adv),
        .q_il     (s1_il),
        .q_be     (s1_be)
    );

    nw_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .in_valid  (s1_valid),
        .in_addr   (s1_addr),
        .in_op     (s1_op),
        .in_adv    (s1_adv),
        .in_il     (s1_il),
        .in_be     (s1_be),
        .out_valid (s2_valid),
        .out_addr  (s2_addr),
        .out_op    (s2_op),
        .out_be    (s2_be),
        .cnt       (burst_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_valid <= 1'b0;
            s3_addr  <= '0;
            s3_op    <= OP_READ;
            s3_be    <= '0;
        end else if (clk_en) begin
            s3_valid <= s2_valid;
            s3_addr  <= s2_addr;
            s3_op    <= s2_op;
            s3_be    <= s2_be;
        end
    end

    assign s2_rd = s2_valid && (s2_op == OP_READ);
    assign s3_wr = s3_valid && (s3_op == OP_WRITE);

    nw_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .rd_valid (s2_rd),
        .rd_addr  (s2_addr),
        .bus_wr   (s3_wr),
        .bus_addr (s3_addr),
        .bus_be   (s3_be),
        .din      (din),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

endmodule

// File: rtl/nw_sram_chk.sv
module nw_sram_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned BURST_W = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               clk_en,
    input logic               sleep,
    input logic [DATA_W-1:0]  dout,
    input logic               dout_oe,
    input logic               s1_valid,
    input logic               s1_adv,
    input logic               s2_rd,
    input logic               s3_valid,
    input logic               s3_wr,
    input logic [BURST_W-1:0] burst_cnt
);

    p_read_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (clk_en && s2_rd) |=> dout_oe);

    p_wr_no_drive_r3: assert property (@(posedge clk) disable iff (rst)
        s3_wr |-> !dout_oe);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(dout) && $stable(dout_oe)));

    p_sleep_block_r7: assert property (@(posedge clk) disable iff (rst)
        (clk_en && sleep) |=> !s1_valid);

    p_load_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clk_en && s1_valid && !s1_adv) |=> (burst_cnt == '0));

    p_adv_step_r9: assert property (@(posedge clk) disable iff (rst)
        (clk_en && s1_valid && s1_adv) |=> (burst_cnt == $past(burst_cnt) + BURST_W'(1)));

    p_oe_read_only_r11: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (s3_valid && !s3_wr));

endmodule

bind nowait_sram nw_sram_chk #(.DATA_W(DATA_W), .BURST_W(nwsram_pkg::BURST_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .sleep     (sleep),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .s1_valid  (s1_valid),
    .s1_adv    (s1_adv),
    .s2_rd     (s2_rd),
    .s3_valid  (s3_valid),
    .s3_wr     (s3_wr),
    .burst_cnt (burst_cnt)
);

// File: tb/test_nowait_sram.sv
`timescale 1ns/1ps
module test_nowait_sram;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en = 1'b0;
    logic          sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic          adv = 1'b0;
    logic          burst_il = 1'b0;
    logic [NB-1:0] byte_we = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    nowait_sram #(.ADDR_W(AW), .LANES(NB), .LANE_W(8)) i_nowait_sram (
        .clk(clk), .rst(rst), .clk_en(clk_en), .sleep(sleep), .addr(addr),
        .we(we), .adv(adv), .burst_il(burst_il), .byte_we(byte_we),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [DW-1:0] model [1<<AW];
    logic [DW-1:0] dsh [3];
    bit            q_rd [$];
    logic [DW-1:0] q_dat [$];
    string         q_tag [$];

    logic [AW-1:0] bbase = '0;
    logic [1:0]    bcnt = '0;
    bit            bil = 0;
    bit            bwr = 0;

    bit            en_at_edge = 0;
    bit            have_prev = 0;
    logic [DW-1:0] prev_d;
    logic          prev_oe;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) en_at_edge <= rst ? 1'b0 : clk_en;

    // Monitor: one expected item per enabled edge; frozen edges must hold the outputs.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (en_at_edge) begin
                if (q_rd.size() == 0) begin
                    check(0, "R2", "scoreboard empty", 0, 0);
                end else begin
                    bit            e_rd;
                    logic [DW-1:0] e_d;
                    string         e_t;
                    e_rd = q_rd.pop_front();
                    e_d  = q_dat.pop_front();
                    e_t  = q_tag.pop_front();
                    check(dout_oe === e_rd, e_t, "dout_oe", {31'd0, dout_oe}, {31'd0, e_rd});
                    if (e_rd) check(dout === e_d, e_t, "dout", dout, e_d);
                end
            end else if (have_prev) begin
                check(dout === prev_d && dout_oe === prev_oe, "R6", "hold", dout, prev_d);
            end
            prev_d    = dout;
            prev_oe   = dout_oe;
            have_prev = 1;
        end
    end

    task automatic push(input bit rd, input logic [DW-1:0] d, input string tag);
        q_rd.push_back(rd);
        q_dat.push_back(d);
        q_tag.push_back(tag);
    endtask

    // Driver: one call per clock; computes the expected result from its own model.
    task automatic step(input bit en, input bit sl, input bit ad, input bit wr, input bit il,
                        input logic [NB-1:0] be, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input string tag);
        logic [AW-1:0] ea;
        bit            ew;
        @(negedge clk);
        clk_en = en; sleep = sl; adv = ad; we = wr; burst_il = il; byte_we = be; addr = a;
        if (en) begin
            din    = dsh[2];
            dsh[2] = dsh[1];
            dsh[1] = dsh[0];
            dsh[0] = '0;
            if (sl) begin
                push(0, '0, tag);
            end else begin
                if (ad) begin
                    bcnt = bcnt + 2'd1;
                    ea = {bbase[AW-1:2], bil ? (bbase[1:0] ^ bcnt) : (bbase[1:0] + bcnt)};
                    ew = bwr;
                end else begin
                    bbase = a; bcnt = 2'd0; bil = il; bwr = wr;
                    ea = a; ew = wr;
                end
                if (ew) begin
                    dsh[0] = wd;
                    for (int i = 0; i < NB; i++)
                        if (be[i]) model[ea][i*8 +: 8] = wd[i*8 +: 8];
                    push(0, '0, tag);
                end else begin
                    push(1, model[ea], tag);
                end
            end
        end
    endtask

    task automatic ld_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string t);
        step(1, 0, 0, 1, 0, 4'hF, a, d, t);
    endtask
    task automatic ld_rd(input logic [AW-1:0] a, input bit il, input string t);
        step(1, 0, 0, 0, il, 4'hF, a, '0, t);
    endtask
    task automatic nap(input string t);
        step(1, 1, 0, 0, 0, 4'h0, '0, '0, t);
    endtask
    task automatic freeze(input string t);
        step(0, 0, 0, 1, 0, 4'hF, 6'h3F, '0, t);
    endtask

    initial begin
        #(4 * 5000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) dsh[i] = '0;
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        push(0, '0, "R1");
        push(0, '0, "R1");
        check(dout_oe === 1'b0, "R1", "dout_oe after reset", {31'd0, dout_oe}, 0);

        // R3: write timing, full words
        for (int i = 0; i < 8; i++) ld_wr(AW'(i), 32'hA000_0000 + 32'(i) * 32'h0111_1111, "R3");
        // R2: read latency
        for (int i = 0; i < 8; i++) ld_rd(AW'(i), 0, "R2");
        // Fill the burst group area
        for (int i = 32; i < 48; i++) ld_wr(AW'(i), 32'hC0DE_0000 + 32'(i), "R9");

        // R4: back-to-back, forwarding at distances 1 and 2
        ld_wr(6'd16, 32'h1111_2222, "R4");
        ld_rd(6'd16, 0, "R4");
        ld_wr(6'd17, 32'h3333_4444, "R4");
        nap("R4");
        ld_rd(6'd17, 0, "R4");
        ld_wr(6'd16, 32'h5555_6666, "R4");
        ld_wr(6'd17, 32'h7777_8888, "R4");
        ld_rd(6'd16, 0, "R4");
        ld_rd(6'd17, 0, "R4");

        // R5: byte lanes, merged with pending writes
        step(1, 0, 0, 1, 0, 4'b0101, 6'd16, 32'hFFFF_FFFF, "R5");
        ld_rd(6'd16, 0, "R5");
        step(1, 0, 0, 1, 0, 4'b1000, 6'd16, 32'h99AA_BBCC, "R5");
        nap("R5");
        ld_rd(6'd16, 0, "R5");
        step(1, 0, 0, 1, 0, 4'b0001, 6'd17, 32'hAAAA_AAAA, "R5");
        step(1, 0, 0, 1, 0, 4'b0010, 6'd17, 32'hBBBB_BBBB, "R5");
        ld_rd(6'd17, 0, "R5");

        // R9 + R8: linear write burst from offset 1; advance ignores we=0
        step(1, 0, 0, 1, 0, 4'hF, 6'h25, 32'h0000_0A01, "R9");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, 32'h0000_0A02, "R8");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, 32'h0000_0A03, "R9");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, 32'h0000_0A04, "R9");
        for (int i = 36; i < 40; i++) ld_rd(AW'(i), 0, "R9");
        // R9: linear read burst from offset 3
        ld_rd(6'h2B, 0, "R9");
        repeat (3) step(1, 0, 1, 0, 0, 4'hF, 6'h00, '0, "R9");

        // R10: interleaved read burst from offset 2; advance ignores we=1 (R8)
        ld_rd(6'h22, 1, "R10");
        step(1, 0, 1, 1, 0, 4'hF, 6'h00, '0, "R8");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, '0, "R10");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, '0, "R10");
        // R10: interleaved write burst from offset 1, read back by loads
        step(1, 0, 0, 1, 1, 4'hF, 6'h2D, 32'h1E00_0001, "R10");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, 32'h1E00_0002, "R10");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, 32'h1E00_0003, "R10");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, 32'h1E00_0004, "R10");
        for (int i = 44; i < 48; i++) ld_rd(AW'(i), 0, "R10");

        // R6: freeze while writes and reads are in flight
        ld_wr(6'd20, 32'hDEAD_0020, "R6");
        ld_rd(6'd16, 0, "R6");
        freeze("R6");
        freeze("R6");
        freeze("R6");
        ld_rd(6'd20, 0, "R6");
        freeze("R6");
        ld_wr(6'd21, 32'hDEAD_0021, "R6");
        freeze("R6");
        ld_rd(6'd21, 0, "R6");

        // R7: sleep blocks loads and advances
        ld_rd(6'h28, 0, "R7");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, '0, "R7");
        step(1, 1, 1, 0, 0, 4'hF, 6'h00, '0, "R7");
        step(1, 1, 0, 1, 0, 4'hF, 6'd20, 32'hBAD0_BAD0, "R7");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, '0, "R7");
        step(1, 0, 1, 0, 0, 4'hF, 6'h00, '0, "R7");
        ld_rd(6'd20, 0, "R7");

        // R11: alternating write/read, one transfer per clock
        for (int i = 0; i < 4; i++) begin
            ld_wr(AW'(24 + i), 32'h0E0E_0000 + 32'(i), "R11");
            ld_rd(AW'(24 + i), 0, "R11");
        end
        ld_rd(6'd24, 0, "R11");
        ld_rd(6'd25, 0, "R11");

        repeat (4) nap("R2");
        @(negedge clk);
        @(negedge clk);
        if (q_rd.size() > 2) check(0, "R2", "results missing", 32'(q_rd.size()), 2);
        done = 1;
        report();
    end

endmodule